// File: doc/BRIEF.md
# Interrupt presenter context with acknowledge

This block holds the interrupt presentation state of one processor. Each priority level has one bit in a pending bitmap. A current processor priority sets the threshold, and a status byte carries an exception bit. The most favored pending priority is derived from the bitmap at all times. Whenever that priority is more favored than the current one, the block sets the exception bit and drives its single interrupt line to the processor.

Software reaches the context through a plain valid/address/data register port. Writing address 0 sets the current priority. Reading address 1 is the acknowledge, a read with side effects. It accepts the most favored pending interrupt: the accepted priority becomes the current priority, the matching pending bit is retired, and the exception bit is dropped. The read returns the status byte from before the accept, packed with the current priority from after it. Addresses 2 and 3 read back the bitmap and the derived pending priority. A separate input marks one priority as pending on any cycle.

Top module: `prio_presenter`

## Requirements
- R1: After reset the current priority is 0xFF, the status byte is 0x00, the bitmap is empty, the pending priority reads 0xFF and irq_out is low.
- R2: A pulse on pend_valid with priority p (0 to 7, lower is more favored) sets bitmap bit 7-p. A read of address 2 returns {0x00, bitmap}. A read of address 3 returns {0x00, pending priority}, which is the lowest pending p, or 0xFF when nothing is pending.
- R3: The cycle after any update, irq_out and the exception bit (bit 7 of the status byte) are high exactly when the pending priority is numerically below the current priority (unsigned compare), unless R7 applies.
- R4: A write to address 0 loads reg_wdata into the current priority. Writes to addresses 1, 2 and 3 change nothing.
- R5: A read of address 1 while the exception bit is set loads the pending priority into the current priority. It clears that priority's bitmap bit, and the pending priority is then recomputed from the remaining bits.
- R6: An acknowledge returns {status byte before the accept, current priority after the accept} on reg_rdata. The status byte before an accept is 0x80.
- R7: An accept clears the exception bit, so irq_out is low in the cycle after it. In the following cycle, irq_out rises again if a remaining pending priority beats the new current priority.
- R8: A read of address 1 while the exception bit is clear changes no state and returns {status byte, current priority}, which is {0x00, current priority}.
- R9: A pend pulse in the same cycle as an accept is recorded, even when it names the priority being accepted.
- R10: reg_rdata is registered. It takes the read result at the clock edge that ends the read cycle, reflects the state before that cycle's updates (except the acknowledge low byte), and holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_valid | input | 1 | Mark pend_prio as pending this cycle |
| pend_prio | input | 3 | Priority to mark pending |
| reg_valid | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 current priority, 1 acknowledge, 2 bitmap, 3 pending priority |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
Two events can fall in the same cycle: a pend arrival and an acknowledge. The bench provokes this by issuing the acknowledge read in the same cycle as a pend pulse. The pulse names either a more favored priority or the very priority being accepted. Each outcome is judged on three things. The interrupt line must drop for one cycle and rise again only when the new arrival beats the accepted priority. The bitmap read back on address 2 must still hold the arrival. The acknowledge data must carry the priority taken before the arrival.

// File: rtl/prio_presenter.sv
module prio_presenter #(
  parameter int LEVELS = 8,
  localparam int PW = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_valid,
  input  logic [PW-1:0] pend_prio,
  input  logic          reg_valid,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          irq_out
);

  function automatic logic [7:0] best(input logic [LEVELS-1:0] m);
    logic [7:0] r;
    r = 8'hFF;
    for (int p = LEVELS - 1; p >= 0; p--)
      if (m[LEVELS-1-p]) r = 8'(p);
    return r;
  endfunction

  logic [LEVELS-1:0] ipb_q, ipb_n, set_m, clr_m;
  logic [7:0]        cppr_q, cppr_n, pipr, pipr_n;
  logic              eo_q;

  wire rd   = reg_valid && !reg_wr;
  wire take = rd && reg_addr == 2'd1 && eo_q;
  wire cwr  = reg_valid && reg_wr && reg_addr == 2'd0;

  assign pipr    = best(ipb_q);
  assign irq_out = eo_q;

  always_comb begin
    for (int i = 0; i < LEVELS; i++) begin
      set_m[i] = pend_valid && (pend_prio == PW'(LEVELS - 1 - i));
      clr_m[i] = take && (pipr == 8'(LEVELS - 1 - i));
    end
  end

  assign ipb_n  = (ipb_q & ~clr_m) | set_m;
  assign cppr_n = take ? pipr : cwr ? reg_wdata : cppr_q;
  assign pipr_n = best(ipb_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipb_q     <= '0;
      cppr_q    <= 8'hFF;
      eo_q      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ipb_q  <= ipb_n;
      cppr_q <= cppr_n;
      eo_q   <= !take && (pipr_n < cppr_n);
      if (rd)
        case (reg_addr)
          2'd0: reg_rdata <= {eo_q, 7'b0, cppr_q};
          2'd1: reg_rdata <= {eo_q, 7'b0, cppr_n};
          2'd2: reg_rdata <= {8'h00, 8'(ipb_q)};
          default: reg_rdata <= {8'h00, pipr};
        endcase
    end
  end

endmodule

// File: rtl/prio_presenter_chk.sv
module prio_presenter_chk #(
  parameter int LEVELS = 8,
  localparam int PW = $clog2(LEVELS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pend_valid,
  input logic [PW-1:0]     pend_prio,
  input logic              reg_valid,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [15:0]       reg_rdata,
  input logic              irq_out,
  input logic [LEVELS-1:0] ipb_q,
  input logic [7:0]        cppr_q,
  input logic [7:0]        pipr
);

  logic [LEVELS-1:0] pmask;
  always_comb
    for (int i = 0; i < LEVELS; i++)
      pmask[i] = (pend_prio == PW'(LEVELS - 1 - i));

  wire ack = reg_valid && !reg_wr && reg_addr == 2'd1;

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> !irq_out);

  // R6
  ack_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> reg_rdata[15:8] == 8'h80);

  // R5
  ack_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> cppr_q == $past(pipr) && reg_rdata[7:0] == $past(pipr));

  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out) |=> reg_rdata == {8'h00, $past(cppr_q)} && cppr_q == $past(cppr_q));

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pipr < cppr_q);

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |=> (ipb_q & $past(pmask)) != '0);

endmodule

bind prio_presenter prio_presenter_chk #(.LEVELS(LEVELS)) chk (.*);

// File: tb/prio_presenter_test.sv
module prio_presenter_test;
  logic clk = 0, rst_n = 0;
  logic pend_valid = 0, reg_valid = 0, reg_wr = 0;
  logic [2:0] pend_prio = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic irq_out;

  prio_presenter uut (.*);

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  logic [7:0] m_ipb, m_cppr;
  logic m_eo;
  logic [15:0] m_rd;

  function automatic logic [7:0] mbest(input logic [7:0] m);
    for (int p = 0; p < 8; p++) if (m[7-p]) return 8'(p);
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic pv, input logic [2:0] pp,
                      input logic v, input logic wr, input logic [1:0] a,
                      input logic [7:0] wd);
    logic take;
    logic [7:0] pm;
    pend_valid = pv; pend_prio = pp; reg_valid = v; reg_wr = wr;
    reg_addr = a; reg_wdata = wd;
    take = v && !wr && a == 2'd1 && m_eo;
    pm = mbest(m_ipb);
    if (v && !wr)
      case (a)
        2'd0: m_rd = {m_eo ? 8'h80 : 8'h00, m_cppr};
        2'd1: m_rd = {m_eo ? 8'h80 : 8'h00, take ? pm : m_cppr};
        2'd2: m_rd = {8'h00, m_ipb};
        default: m_rd = {8'h00, pm};
      endcase
    if (take) begin
      m_cppr = pm;
      m_ipb  = m_ipb & ~(8'h80 >> pm);
    end else if (v && wr && a == 2'd0) m_cppr = wd;
    if (pv) m_ipb = m_ipb | (8'h80 >> pp);
    m_eo = !take && (mbest(m_ipb) < m_cppr);
    @(negedge clk);
    pend_valid = 0; reg_valid = 0; reg_wr = 0;
    chk({tag, " irq"}, {15'b0, irq_out}, {15'b0, m_eo});
    chk((v && !wr) ? {tag, " rdata"} : "R10 rdata hold", reg_rdata, m_rd);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    m_ipb = 0; m_cppr = 8'hFF; m_eo = 0; m_rd = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 irq", {15'b0, irq_out}, 16'h0);
    chk("R1 rdata", reg_rdata, 16'h0);
    step("R1 status", 0, 0, 1, 0, 2'd0, 0);
    chk("R1 cppr", reg_rdata, 16'h00FF);
    step("R1 pipr", 0, 0, 1, 0, 2'd3, 0);
    chk("R1 pipr val", reg_rdata, 16'h00FF);
    step("R1 bitmap", 0, 0, 1, 0, 2'd2, 0);

    for (int c = 0; c < 9; c++)
      for (int p = 0; p < 8; p++) begin
        do_reset();
        step("R4 write", 0, 0, 1, 1, 2'd0, (c == 8) ? 8'hFF : 8'(c));
        step("R2 pend", 1, 3'(p), 0, 0, 0, 0);
        step("R3 compare", 0, 0, 1, 0, 2'd3, 0);
        step("R5 R6 ack", 0, 0, 1, 0, 2'd1, 0);
        idle("R7 after ack");
        step("R5 cppr", 0, 0, 1, 0, 2'd0, 0);
        step("R5 bitmap", 0, 0, 1, 0, 2'd2, 0);
      end

    do_reset();
    for (int p = 7; p >= 0; p--) step("R2 fill", 1, 3'(p), 1, 0, 2'd3, 0);
    step("R2 full", 0, 0, 1, 0, 2'd2, 0);
    for (int k = 0; k < 8; k++) begin
      step("R4 reopen", 0, 0, 1, 1, 2'd0, 8'hFF);
      step("R6 order ack", 0, 0, 1, 0, 2'd1, 0);
      chk("R5 order", reg_rdata, {8'h80, 8'(k)});
      idle("R7 quiet");
      step("R2 remain", 0, 0, 1, 0, 2'd3, 0);
    end

    do_reset();
    step("R4 write", 0, 0, 1, 1, 2'd0, 8'h03);
    step("R2 pend", 1, 3'd5, 0, 0, 0, 0);
    step("R8 ack no eo", 0, 0, 1, 0, 2'd1, 0);
    chk("R8 value", reg_rdata, 16'h0003);
    step("R8 bitmap kept", 0, 0, 1, 0, 2'd2, 0);
    step("R4 ignored write", 0, 0, 1, 1, 2'd2, 8'h00);
    step("R4 ignored write", 0, 0, 1, 1, 2'd1, 8'h00);
    step("R4 cppr kept", 0, 0, 1, 0, 2'd0, 0);
    chk("R4 value", reg_rdata, 16'h0003);
    step("R4 bitmap kept", 0, 0, 1, 0, 2'd2, 0);
    idle("R10 hold");

    do_reset();
    step("R2 pend", 1, 3'd4, 0, 0, 0, 0);
    step("R9 ack plus better", 1, 3'd1, 1, 0, 2'd1, 0);
    chk("R9 ack data", reg_rdata, 16'h8004);
    chk("R7 dropped", {15'b0, irq_out}, 16'h0);
    idle("R7 reraise");
    chk("R7 raised", {15'b0, irq_out}, 16'h1);
    step("R9 bitmap", 0, 0, 1, 0, 2'd2, 0);

    do_reset();
    step("R2 pend", 1, 3'd4, 0, 0, 0, 0);
    step("R9 ack plus same", 1, 3'd4, 1, 0, 2'd1, 0);
    idle("R7 no reraise");
    step("R9 same kept", 0, 0, 1, 0, 2'd2, 0);
    chk("R9 same value", reg_rdata, 16'h0008);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule